// File: doc/BRIEF.md
# Serial camera sync-code deserializer

This block sits behind the receivers and clock recovery of a serial camera link. It takes one sampled data bit per qualified cycle and packs the bits into bytes, least significant bit first. It then presents those bytes on an 8-bit pixel bus with a one-cycle valid pulse. Byte boundaries are unknown at power-up. The block hunts bit by bit for an embedded synchronization code and starts emitting bytes only once it has found one. Every code is four bytes long: FF, 00, 00, then a code byte.

A mode pin selects between two uses of the stream:

- **Pass mode.** Everything received after alignment, code bytes included, goes straight to the bus.
- **Strip mode.** Code bytes are removed and their meaning is turned into a horizontal sync level and a vertical sync level. Pixel bytes go through a three-byte look-behind line. A byte sequence that only partly resembles a code is therefore released as ordinary data, in its original order.

An enable input controls an output-enable pin for the pads. While disabled, the data, valid and sync outputs are forced low.

Top module: `camsync_deser`

## Requirements
- R1: Bits are packed least significant bit first. In pass mode, a completed byte appears on `pix_data` with `pix_vld` high for exactly one cycle. That cycle begins two rising edges after the edge that samples the byte's eighth bit; one edge after that sample, `pix_vld` is still low.
- R2: After reset, `pix_vld` stays low until the bit stream contains FF, 00, 00 followed by a code byte in the range 00 to 03, at any bit offset. This first code is never output, but in strip mode its sync meaning still takes effect.
- R3: In pass mode (`strip_mode`=0), every byte after alignment is output in arrival order, sync-code bytes included. `hsync` and `vsync` stay low.
- R4: In strip mode (`strip_mode`=1), none of the four bytes of a recognized code is output. Each pixel byte is output when the third byte after it completes, with R1's timing relative to that later byte.
- R5: In strip mode, code byte 02 sets `vsync`, 03 clears `vsync`, 00 sets `hsync` and 01 clears `hsync`. The change is visible at the same point R1 gives for a byte.
- R6: A sequence that starts like a code but breaks off is released as data bytes in arrival order. Examples are FF 00 05, and FF 00 00 followed by a code byte above 03.
- R7: Cycles with `ser_vld` low, including gaps inside a byte, change neither alignment nor the bytes produced.
- R8: With `en` low, `out_oe` is 0 and `pix_data`, `pix_vld`, `hsync` and `vsync` are 0. With `en` high, `out_oe` is 1.
- R9: Synchronous active-high reset clears `pix_vld`, `pix_data`, `hsync` and `vsync` to 0 and drops alignment.
- R10: With a run of FF bytes before 00 00 and a code byte, the FF bytes before the last one are released as data and the code is still recognized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Output enable request |
| strip_mode | input | 1 | 1 = remove codes and drive sync, 0 = pass all bytes |
| ser_vld | input | 1 | Qualifies `ser_bit` this cycle |
| ser_bit | input | 1 | Sampled serial data bit |
| pix_data | output | 8 | Parallel byte output |
| pix_vld | output | 1 | One-cycle strobe for `pix_data` |
| hsync | output | 1 | Line-active level (strip mode) |
| vsync | output | 1 | Frame-active level (strip mode) |
| out_oe | output | 1 | Pad output enable |

## Verification
A byte's result is due two rising edges after the edge that samples its eighth bit. That is one register in the aligner and one in the code filter. In strip mode the pixel that result carries is the one three bytes older.

The bench drives bits on falling edges and drops `ser_vld` after the last bit. At the first falling edge after that it checks that `pix_vld` is still low, and at the following falling edge it samples data and sync levels. The table of expected values is built with the three-byte delay worked out row by row, so early or late release shows up as a mismatch.

// File: rtl/camsync_pkg.sv
package camsync_pkg;

    localparam int BYTE_W   = 8;
    localparam int SYNC_LEN = 4;
    localparam int HOLD     = SYNC_LEN - 1;
    localparam int WIN_W    = BYTE_W * SYNC_LEN;
    localparam int PRE_W    = BYTE_W * HOLD;
    localparam int CNT_W    = $clog2(BYTE_W);
    localparam int CODE_W   = 2;

    localparam logic [BYTE_W-1:0] PRE_ONES  = '1;
    localparam logic [BYTE_W-1:0] PRE_ZEROS = '0;

    typedef enum logic [CODE_W-1:0] {
        CODE_LINE_ON   = 2'd0,
        CODE_LINE_OFF  = 2'd1,
        CODE_FRAME_ON  = 2'd2,
        CODE_FRAME_OFF = 2'd3
    } code_e;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] data;
    } slot_t;

    typedef struct packed {
        logic hs;
        logic vs;
    } sync_t;

    // Oldest byte in the low bits.
    function automatic logic is_prefix(logic [PRE_W-1:0] p);
        return p == {PRE_ZEROS, PRE_ZEROS, PRE_ONES};
    endfunction

    function automatic logic is_code(logic [BYTE_W-1:0] b);
        return b[BYTE_W-1:CODE_W] == '0;
    endfunction

    function automatic sync_t apply_code(sync_t cur, logic [CODE_W-1:0] c);
        sync_t r;
        r = cur;
        case (code_e'(c))
            CODE_LINE_ON:   r.hs = 1'b1;
            CODE_LINE_OFF:  r.hs = 1'b0;
            CODE_FRAME_ON:  r.vs = 1'b1;
            CODE_FRAME_OFF: r.vs = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/camsync_aligner.sv
module camsync_aligner
    import camsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic              locked,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              lock_stb,
    output logic [CODE_W-1:0] lock_code
);

    logic [WIN_W-1:0]  win;
    logic [WIN_W-1:0]  win_n;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] sh_n;
    logic [CNT_W-1:0]  cnt;
    logic              hit;

    // New bits enter at the top, so the oldest bit sits at bit 0 (LSB first).
    assign win_n = {bit_in, win[WIN_W-1:1]};
    assign sh_n  = {bit_in, sh[BYTE_W-1:1]};
    assign hit   = is_prefix(win_n[PRE_W-1:0]) && is_code(win_n[WIN_W-1 -: BYTE_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            win       <= '0;
            sh        <= '0;
            cnt       <= '0;
            locked    <= 1'b0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
            lock_stb  <= 1'b0;
            lock_code <= '0;
        end else begin
            byte_vld <= 1'b0;
            lock_stb <= 1'b0;
            if (bit_vld) begin
                if (!locked) begin
                    win <= win_n;
                    if (hit) begin
                        locked    <= 1'b1;
                        cnt       <= '0;
                        lock_stb  <= 1'b1;
                        lock_code <= win_n[PRE_W +: CODE_W];
                    end
                end else begin
                    sh  <= sh_n;
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(BYTE_W - 1)) begin
                        byte_vld  <= 1'b1;
                        byte_data <= sh_n;
                    end
                end
            end
        end
    end

    AST_BYTE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> locked); // R2
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked); // R2
    AST_BYTE_SPACING: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld); // R7

endmodule

// File: rtl/camsync_codefilt.sv
module camsync_codefilt
    import camsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strip,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              lock_stb,
    input  logic [CODE_W-1:0] lock_code,
    output logic              o_vld,
    output logic [BYTE_W-1:0] o_data,
    output logic              o_hs,
    output logic              o_vs
);

    // line[0] newest, line[HOLD-1] oldest
    slot_t [HOLD-1:0] line;
    slot_t [HOLD-1:0] line_n;
    logic [PRE_W-1:0] pre_vec;
    logic             all_vld;
    logic             match;
    sync_t            sync_q;

    always_comb begin
        all_vld = 1'b1;
        for (int i = 0; i < HOLD; i++) begin
            pre_vec[i*BYTE_W +: BYTE_W] = line[HOLD-1-i].data;
            all_vld = all_vld & line[i].vld;
        end
    end

    assign match = strip && all_vld && is_prefix(pre_vec) && is_code(byte_data);

    always_comb begin
        line_n = line;
        if (!strip || (byte_vld && match)) begin
            line_n = '0;
        end else if (byte_vld) begin
            for (int i = HOLD-1; i > 0; i--) begin
                line_n[i] = line[i-1];
            end
            line_n[0] = '{vld: 1'b1, data: byte_data};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line   <= '0;
            o_vld  <= 1'b0;
            o_data <= '0;
            sync_q <= '0;
        end else begin
            line  <= line_n;
            o_vld <= 1'b0;
            if (!strip) begin
                sync_q <= '0;
                if (byte_vld) begin
                    o_vld  <= 1'b1;
                    o_data <= byte_data;
                end
            end else begin
                if (lock_stb) begin
                    sync_q <= apply_code(sync_q, lock_code);
                end
                if (byte_vld) begin
                    if (match) begin
                        sync_q <= apply_code(sync_q, byte_data[CODE_W-1:0]);
                    end else if (line[HOLD-1].vld) begin
                        o_vld  <= 1'b1;
                        o_data <= line[HOLD-1].data;
                    end
                end
            end
        end
    end

    assign o_hs = sync_q.hs;
    assign o_vs = sync_q.vs;

    AST_OUT_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (rst)
        o_vld |-> $past(byte_vld)); // R1
    AST_PASS_SYNC_LOW: assert property (@(posedge clk) disable iff (rst)
        !strip |=> (!o_hs && !o_vs)); // R3
    AST_CODE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && match) |=> !o_vld); // R4
    AST_SYNC_ON_CODE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (strip && !byte_vld && !lock_stb) |=> $stable({o_hs, o_vs})); // R5

endmodule

// File: rtl/camsync_deser.sv
module camsync_deser
    import camsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              strip_mode,
    input  logic              ser_vld,
    input  logic              ser_bit,
    output logic [BYTE_W-1:0] pix_data,
    output logic              pix_vld,
    output logic              hsync,
    output logic              vsync,
    output logic              out_oe
);

    logic              locked;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_data;
    logic              lock_stb;
    logic [CODE_W-1:0] lock_code;
    logic              f_vld;
    logic [BYTE_W-1:0] f_data;
    logic              f_hs;
    logic              f_vs;

    camsync_aligner u_align (
        .clk       (clk),
        .rst       (rst),
        .bit_vld   (ser_vld),
        .bit_in    (ser_bit),
        .locked    (locked),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .lock_stb  (lock_stb),
        .lock_code (lock_code)
    );

    camsync_codefilt u_filt (
        .clk       (clk),
        .rst       (rst),
        .strip     (strip_mode),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .lock_stb  (lock_stb),
        .lock_code (lock_code),
        .o_vld     (f_vld),
        .o_data    (f_data),
        .o_hs      (f_hs),
        .o_vs      (f_vs)
    );

    assign out_oe   = en;
    assign pix_data = en ? f_data : '0;
    assign pix_vld  = en & f_vld;
    assign hsync    = en & f_hs;
    assign vsync    = en & f_vs;

    AST_NO_OUT_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        !locked |-> !pix_vld); // R2

endmodule

// File: tb/camsync_deser_tb.sv
module camsync_deser_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic       strip_mode = 1'b1;
    logic       ser_vld = 1'b0;
    logic       ser_bit = 1'b0;
    logic [7:0] pix_data;
    logic       pix_vld;
    logic       hsync;
    logic       vsync;
    logic       out_oe;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    camsync_deser dut_i (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .strip_mode (strip_mode),
        .ser_vld    (ser_vld),
        .ser_bit    (ser_bit),
        .pix_data   (pix_data),
        .pix_vld    (pix_vld),
        .hsync      (hsync),
        .vsync      (vsync),
        .out_oe     (out_oe)
    );

    // {in[7:0], gap[3:0], exp_vld, exp_data[7:0], exp_hs, exp_vs, tag[3:0]}
    localparam int NV = 36;
    localparam logic [26:0] VEC [NV] = '{
        {8'h11,4'd0,1'b0,8'h00,1'b0,1'b0,4'd2},
        {8'hFF,4'd0,1'b0,8'h00,1'b0,1'b0,4'd2},
        {8'h00,4'd5,1'b0,8'h00,1'b0,1'b0,4'd7},
        {8'h00,4'd0,1'b0,8'h00,1'b0,1'b0,4'd2},
        {8'h02,4'd0,1'b0,8'h00,1'b0,1'b1,4'd2},
        {8'h10,4'd0,1'b0,8'h00,1'b0,1'b1,4'd4},
        {8'h20,4'd0,1'b0,8'h00,1'b0,1'b1,4'd4},
        {8'hFF,4'd0,1'b0,8'h00,1'b0,1'b1,4'd4},
        {8'h00,4'd0,1'b1,8'h10,1'b0,1'b1,4'd4},
        {8'h00,4'd0,1'b1,8'h20,1'b0,1'b1,4'd4},
        {8'h00,4'd0,1'b0,8'h00,1'b1,1'b1,4'd4},
        {8'h41,4'd0,1'b0,8'h00,1'b1,1'b1,4'd4},
        {8'hFF,4'd0,1'b0,8'h00,1'b1,1'b1,4'd6},
        {8'h00,4'd5,1'b0,8'h00,1'b1,1'b1,4'd7},
        {8'h05,4'd0,1'b1,8'h41,1'b1,1'b1,4'd6},
        {8'hFF,4'd0,1'b1,8'hFF,1'b1,1'b1,4'd6},
        {8'h00,4'd0,1'b1,8'h00,1'b1,1'b1,4'd6},
        {8'h00,4'd0,1'b1,8'h05,1'b1,1'b1,4'd6},
        {8'h01,4'd0,1'b0,8'h00,1'b0,1'b1,4'd4},
        {8'hFF,4'd0,1'b0,8'h00,1'b0,1'b1,4'd10},
        {8'hFF,4'd0,1'b0,8'h00,1'b0,1'b1,4'd10},
        {8'h00,4'd0,1'b0,8'h00,1'b0,1'b1,4'd10},
        {8'h00,4'd0,1'b1,8'hFF,1'b0,1'b1,4'd10},
        {8'h00,4'd0,1'b0,8'h00,1'b1,1'b1,4'd10},
        {8'hFF,4'd0,1'b0,8'h00,1'b1,1'b1,4'd6},
        {8'h00,4'd0,1'b0,8'h00,1'b1,1'b1,4'd6},
        {8'h00,4'd0,1'b0,8'h00,1'b1,1'b1,4'd6},
        {8'h07,4'd5,1'b1,8'hFF,1'b1,1'b1,4'd7},
        {8'hFF,4'd0,1'b1,8'h00,1'b1,1'b1,4'd6},
        {8'h00,4'd0,1'b1,8'h00,1'b1,1'b1,4'd6},
        {8'h00,4'd0,1'b1,8'h07,1'b1,1'b1,4'd6},
        {8'h01,4'd0,1'b0,8'h00,1'b0,1'b1,4'd4},
        {8'hFF,4'd0,1'b0,8'h00,1'b0,1'b1,4'd4},
        {8'h00,4'd0,1'b0,8'h00,1'b0,1'b1,4'd4},
        {8'h00,4'd0,1'b0,8'h00,1'b0,1'b1,4'd4},
        {8'h03,4'd0,1'b0,8'h00,1'b0,1'b0,4'd4}
    };

    function automatic string tag_name(logic [3:0] t);
        case (t)
            4'd2:    return "R2";
            4'd4:    return "R4";
            4'd6:    return "R6";
            4'd7:    return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Drives n bits LSB first, optional idle gap before bit 4, then one idle
    // cycle. Returns at the falling edge one clock after the last bit sample.
    task automatic shift_bits(input logic [7:0] b, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            if (i == 4) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    ser_vld = 1'b0;
                end
            end
            @(negedge clk);
            ser_vld = 1'b1;
            ser_bit = b[i];
        end
        @(negedge clk);
        ser_vld = 1'b0;
    endtask

    // Sends a byte, checks the early point, and returns at the result point.
    task automatic send_byte(input logic [7:0] b, input int gap, input string req);
        shift_bits(b, 8, gap);
        chk(req, 32'(pix_vld), 32'd0);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ser_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        // Reset state (R9)
        en = 1'b1;
        strip_mode = 1'b1;
        do_reset();
        @(negedge clk);
        chk("R9 vld", 32'(pix_vld), 32'd0);
        chk("R9 data", 32'(pix_data), 32'd0);
        chk("R9 hs", 32'(hsync), 32'd0);
        chk("R9 vs", 32'(vsync), 32'd0);
        chk("R8 oe", 32'(out_oe), 32'd1);

        // Strip-mode table, stream misaligned by three bits (R2, R4..R7, R10)
        shift_bits(8'b0000_0101, 3, 0);
        for (int k = 0; k < NV; k++) begin
            logic [26:0] v;
            v = VEC[k];
            send_byte(v[26:19], int'(v[18:15]), tag_name(v[3:0]));
            chk(tag_name(v[3:0]), 32'(pix_vld), 32'(v[14]));
            if (v[14]) chk(tag_name(v[3:0]), 32'(pix_data), 32'(v[13:6]));
            chk("R5 hs", 32'(hsync), 32'(v[5]));
            chk("R5 vs", 32'(vsync), 32'(v[4]));
        end

        // Pass mode (R1, R3, R8)
        strip_mode = 1'b0;
        do_reset();
        shift_bits(8'b0000_0001, 2, 0);
        send_byte(8'hFF, 0, "R2"); chk("R2", 32'(pix_vld), 32'd0);
        send_byte(8'h00, 0, "R2"); chk("R2", 32'(pix_vld), 32'd0);
        send_byte(8'h00, 0, "R2"); chk("R2", 32'(pix_vld), 32'd0);
        send_byte(8'h00, 0, "R2"); chk("R2", 32'(pix_vld), 32'd0);
        chk("R3 hs", 32'(hsync), 32'd0);
        send_byte(8'h1E, 0, "R1 early");
        chk("R1 vld", 32'(pix_vld), 32'd1);
        chk("R1 data", 32'(pix_data), 32'h1E);
        @(negedge clk);
        chk("R1 pulse", 32'(pix_vld), 32'd0);
        send_byte(8'hFF, 0, "R3"); chk("R3", 32'(pix_data), 32'hFF);
        send_byte(8'h00, 0, "R3"); chk("R3", 32'(pix_vld), 32'd1);
        send_byte(8'h00, 0, "R3"); chk("R3", 32'(pix_data), 32'h00);
        send_byte(8'h02, 2, "R3"); chk("R3", 32'(pix_data), 32'h02);
        chk("R3 vld", 32'(pix_vld), 32'd1);
        chk("R3 vs", 32'(vsync), 32'd0);
        en = 1'b0;
        send_byte(8'h33, 0, "R8");
        chk("R8 vld", 32'(pix_vld), 32'd0);
        chk("R8 data", 32'(pix_data), 32'd0);
        chk("R8 oe", 32'(out_oe), 32'd0);
        en = 1'b1;
        send_byte(8'h44, 0, "R8");
        chk("R8 vld", 32'(pix_vld), 32'd1);
        chk("R8 data", 32'(pix_data), 32'h44);
        chk("R8 oe", 32'(out_oe), 32'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule